// File: doc/BRIEF.md
# Serial Receive Interrupt Flag Controller

This block keeps the receive-side status flags of a FIFO-based serial port and derives three level interrupt requests from them: data ready, receive error, and break. Five single-cycle event pulses come from the receiver and set the flags: FIFO full, data ready, error, break and overrun. A small CPU register port reads the flags and clears them with a handshake. A flag can only be cleared by writing zero to it after a read has returned it as one. The same port also writes the control register and the transmit data register.

The control register holds a receive interrupt enable, an error interrupt enable and a transmit enable. The data-ready request depends only on the receive interrupt enable. The error and break requests stay active while either of the two enables is set. Writing the transmit data register while transmission is enabled sends a one-cycle start strobe, together with the byte, to a shifter outside the block. All ports are plain control and status pins. The start strobe is fire-and-forget, and there is no back-pressure path.

Top module: `sif_irq_ctrl`

## Requirements
- R1: After reset, all three control enables, all five flags and all three interrupt outputs are 0, and `tx_start` is 0.
- R2: A 1 on `rx_evt[i]` at a clock edge sets flag i at that edge. The bit order is 0 = FIFO full, 1 = data ready, 2 = error, 3 = break, 4 = overrun. A read with `cpu_addr`=0 returns the flags in `cpu_rdata[4:0]` combinationally, with the upper bits zero.
- R3: Each flag has a hidden mark. A read of address 0 (`cpu_re`=1, `cpu_we`=0) sets the mark of every flag that is 1. A write to address 0 clears flag i only if `cpu_wdata[i]`=0 and its mark is set. Writing 1 to a flag bit leaves that flag unchanged. Any write to address 0 clears all marks.
- R4: If a set event and a valid clear for the same flag arrive in the same cycle, the flag stays 1.
- R5: `irq_rx` is registered, with one cycle of latency. It equals the receive enable AND (FIFO full OR data ready). Clearing the receive enable removes the request.
- R6: `irq_err` is registered, with one cycle of latency. It equals the error flag AND (receive enable OR error enable).
- R7: `irq_brk` is registered, with one cycle of latency. It equals (break OR overrun) AND (receive enable OR error enable).
- R8: A write to address 1 loads the control register. Bit 0 is the receive enable, bit 1 is the error enable and bit 2 is the transmit enable. A read of address 1 returns these bits in `cpu_rdata[2:0]`.
- R9: A write to address 2 while the transmit enable is 1 pulses `tx_start` for one cycle at the next edge, with `tx_byte` equal to the written data. While the transmit enable is 0, such a write produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_evt | input | 5 | Receiver event pulses (full, ready, error, break, overrun) |
| cpu_addr | input | 2 | Register address: 0 flags, 1 control, 2 transmit data |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe (ignored when `cpu_we` is 1) |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational from the addressed register |
| tx_start | output | 1 | One-cycle transmit start strobe |
| tx_byte | output | 8 | Byte to transmit, valid with `tx_start` |
| irq_rx | output | 1 | Data-ready interrupt request |
| irq_err | output | 1 | Receive-error interrupt request |
| irq_brk | output | 1 | Break/overrun interrupt request |

## Verification
The bench targets a zero written without a prior read. A design that ignores the mark would lose a flag software never saw. It also targets a ones-write sitting between the read and the zero-write. That write must consume the mark, so a design that keeps it would clear the flag too early. The bench checks a set event colliding with a clear, where letting the clear win drops a receive event. It checks clearing only one of the two enables, which must silence the data-ready request but keep the error and break requests active. It also writes the transmit register while transmission is disabled; a design that got this wrong would start a spurious frame.

// File: rtl/sif_pkg.sv
package sif_pkg;
  localparam int unsigned NFLAG    = 5;
  localparam int unsigned FL_FULL  = 0;
  localparam int unsigned FL_RDY   = 1;
  localparam int unsigned FL_ERR   = 2;
  localparam int unsigned FL_BRK   = 3;
  localparam int unsigned FL_OVR   = 4;

  localparam int unsigned ADR_STAT = 0;
  localparam int unsigned ADR_CTRL = 1;
  localparam int unsigned ADR_TXD  = 2;

  localparam int unsigned CB_RXIE  = 0;
  localparam int unsigned CB_ERRIE = 1;
  localparam int unsigned CB_TXEN  = 2;
  localparam int unsigned CTRL_W   = 3;

  typedef struct packed {
    logic tx_en;
    logic err_ie;
    logic rx_ie;
  } ctrl_t;
endpackage

// File: rtl/sif_flag_cell.sv
module sif_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  output logic flag
);
  logic mark;

  // A set event has priority over any software clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (set_evt) begin
      flag <= 1'b1;
    end else if (wr_stb && !wr_bit && mark) begin
      flag <= 1'b0;
    end
  end

  // The mark records that software has seen this flag as one.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark <= 1'b0;
    end else if (wr_stb) begin
      mark <= 1'b0;
    end else if (rd_stb && flag) begin
      mark <= 1'b1;
    end
  end
endmodule

// File: rtl/sif_flag_bank.sv
module sif_flag_bank #(
  parameter int unsigned NF = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_evt,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [NF-1:0] wr_bits,
  output logic [NF-1:0] flags
);
  for (genvar i = 0; i < NF; i++) begin : g_cell
    sif_flag_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt (set_evt[i]),
      .rd_stb  (rd_stb),
      .wr_stb  (wr_stb),
      .wr_bit  (wr_bits[i]),
      .flag    (flags[i])
    );
  end
endmodule

// File: rtl/sif_ctrl_reg.sv
module sif_ctrl_reg
  import sif_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_txd,
  input  logic [DW-1:0] wdata,
  output ctrl_t         ctrl,
  output logic          tx_start,
  output logic [DW-1:0] tx_byte
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.rx_ie  <= wdata[CB_RXIE];
      ctrl.err_ie <= wdata[CB_ERRIE];
      ctrl.tx_en  <= wdata[CB_TXEN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_start <= 1'b0;
      tx_byte  <= '0;
    end else begin
      tx_start <= wr_txd && ctrl.tx_en;
      if (wr_txd && ctrl.tx_en) tx_byte <= wdata;
    end
  end
endmodule

// File: rtl/sif_irq_gen.sv
module sif_irq_gen
  import sif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flags,
  input  ctrl_t            ctrl,
  output logic             irq_rx,
  output logic             irq_err,
  output logic             irq_brk
);
  logic err_path_en;
  assign err_path_en = ctrl.rx_ie | ctrl.err_ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_rx  <= 1'b0;
      irq_err <= 1'b0;
      irq_brk <= 1'b0;
    end else begin
      irq_rx  <= ctrl.rx_ie && (flags[FL_FULL] || flags[FL_RDY]);
      irq_err <= err_path_en && flags[FL_ERR];
      irq_brk <= err_path_en && (flags[FL_BRK] || flags[FL_OVR]);
    end
  end
endmodule

// File: rtl/sif_irq_ctrl.sv
module sif_irq_ctrl
  import sif_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFLAG-1:0]  rx_evt,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic              cpu_re,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_byte,
  output logic              irq_rx,
  output logic              irq_err,
  output logic              irq_brk
);
  localparam int unsigned PAD_F = DATA_W - NFLAG;
  localparam int unsigned PAD_C = DATA_W - CTRL_W;

  logic [NFLAG-1:0] flags;
  ctrl_t            ctrl_q;
  logic             sel_stat, sel_ctrl, sel_txd;
  logic             rd_stat, wr_stat;

  assign sel_stat = (cpu_addr == ADDR_W'(ADR_STAT));
  assign sel_ctrl = (cpu_addr == ADDR_W'(ADR_CTRL));
  assign sel_txd  = (cpu_addr == ADDR_W'(ADR_TXD));
  assign rd_stat  = cpu_re && !cpu_we && sel_stat;
  assign wr_stat  = cpu_we && sel_stat;

  sif_flag_bank #(.NF(NFLAG)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (rx_evt),
    .rd_stb  (rd_stat),
    .wr_stb  (wr_stat),
    .wr_bits (cpu_wdata[NFLAG-1:0]),
    .flags   (flags)
  );

  sif_ctrl_reg #(.DW(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (cpu_we && sel_ctrl),
    .wr_txd   (cpu_we && sel_txd),
    .wdata    (cpu_wdata),
    .ctrl     (ctrl_q),
    .tx_start (tx_start),
    .tx_byte  (tx_byte)
  );

  sif_irq_gen u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .ctrl    (ctrl_q),
    .irq_rx  (irq_rx),
    .irq_err (irq_err),
    .irq_brk (irq_brk)
  );

  always_comb begin
    cpu_rdata = '0;
    if (sel_stat)      cpu_rdata = {{PAD_F{1'b0}}, flags};
    else if (sel_ctrl) cpu_rdata = {{PAD_C{1'b0}}, ctrl_q};
  end
endmodule

// File: rtl/sif_irq_ctrl_chk.sv
module sif_irq_ctrl_chk
  import sif_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NFLAG-1:0]  rx_evt,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic              tx_start,
  input logic              irq_rx,
  input logic              irq_err,
  input logic              irq_brk,
  input logic [NFLAG-1:0]  flags,
  input logic              rx_ie,
  input logic              err_ie,
  input logic              tx_en
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_fl
    // R2, R4: an event always leaves the flag set
    a_r2_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      rx_evt[i] |=> flags[i]);
    // R3: a flag only falls after a zero written to its bit at the flag address
    a_r3_clear_by_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[i]) |-> $past(cpu_we && cpu_addr == ADDR_W'(ADR_STAT) && !cpu_wdata[i]));
  end

  a_r5_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> $past(rx_ie));

  a_r6_err_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FL_ERR] && (rx_ie || err_ie)) |=> irq_err);

  a_r7_brk_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags[FL_BRK] || flags[FL_OVR]) && (rx_ie || err_ie)) |=> irq_brk);

  a_r9_tx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> $past(cpu_we && cpu_addr == ADDR_W'(ADR_TXD) && tx_en));
endmodule

bind sif_irq_ctrl sif_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_evt    (rx_evt),
  .cpu_addr  (cpu_addr),
  .cpu_we    (cpu_we),
  .cpu_wdata (cpu_wdata),
  .tx_start  (tx_start),
  .irq_rx    (irq_rx),
  .irq_err   (irq_err),
  .irq_brk   (irq_brk),
  .flags     (flags),
  .rx_ie     (ctrl_q.rx_ie),
  .err_ie    (ctrl_q.err_ie),
  .tx_en     (ctrl_q.tx_en)
);

// File: tb/tb_sif_irq_ctrl.sv
module tb_sif_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] rx_evt = '0;
  logic [1:0] cpu_addr = '0;
  logic       cpu_we = 1'b0, cpu_re = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata, tx_byte;
  logic       tx_start, irq_rx, irq_err, irq_brk;

  int errs = 0, checks = 0;
  bit done = 1'b0;

  // bench model state
  logic [4:0] m_f = '0, m_mk = '0;
  logic [2:0] m_c = '0;
  logic       m_irx = 0, m_ierr = 0, m_ibrk = 0, m_tx = 0;
  logic [7:0] m_txb = '0;

  always #4 clk = ~clk;

  sif_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .cpu_addr(cpu_addr),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .tx_start(tx_start), .tx_byte(tx_byte),
    .irq_rx(irq_rx), .irq_err(irq_err), .irq_brk(irq_brk)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] m_read(logic [1:0] a);
    if (a == 2'd0) return {3'b0, m_f};
    if (a == 2'd1) return {5'b0, m_c};
    return 8'h00;
  endfunction

  task automatic outs_chk();
    chk("R5 irq_rx", {7'b0, irq_rx}, {7'b0, m_irx});
    chk("R6 irq_err", {7'b0, irq_err}, {7'b0, m_ierr});
    chk("R7 irq_brk", {7'b0, irq_brk}, {7'b0, m_ibrk});
    chk("R9 tx_start", {7'b0, tx_start}, {7'b0, m_tx});
    if (m_tx) chk("R9 tx_byte", tx_byte, m_txb);
  endtask

  // one cycle: entered and left just after a falling edge
  task automatic cyc(logic [4:0] ev, logic [1:0] a, logic we, logic re,
                     logic [7:0] wd, string tag);
    logic [4:0] nf, nmk;
    logic       rd;
    rx_evt = ev; cpu_addr = a; cpu_we = we; cpu_re = re; cpu_wdata = wd;
    #1;
    if (re && !we) chk(tag, cpu_rdata, m_read(a));
    rd = re && !we;
    for (int i = 0; i < 5; i++) begin
      nf[i] = m_f[i];
      if (ev[i]) nf[i] = 1'b1;
      else if (we && a == 2'd0 && !wd[i] && m_mk[i]) nf[i] = 1'b0;
      nmk[i] = m_mk[i];
      if (we && a == 2'd0) nmk[i] = 1'b0;
      else if (rd && a == 2'd0 && m_f[i]) nmk[i] = 1'b1;
    end
    m_irx  = m_c[0] & (m_f[0] | m_f[1]);
    m_ierr = (m_c[0] | m_c[1]) & m_f[2];
    m_ibrk = (m_c[0] | m_c[1]) & (m_f[3] | m_f[4]);
    m_tx   = we && a == 2'd2 && m_c[2];
    if (m_tx) m_txb = wd;
    if (we && a == 2'd1) m_c = wd[2:0];
    m_f = nf; m_mk = nmk;
    @(negedge clk);
    outs_chk();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk("R1 irq", {5'b0, irq_rx, irq_err, irq_brk}, 8'h00);
    chk("R1 tx_start", {7'b0, tx_start}, 8'h00);
    cyc(5'h00, 2'd1, 0, 1, 8'h00, "R1 ctrl");
    cyc(5'h00, 2'd0, 0, 1, 8'h00, "R1 flags");

    // R8 control read-back, error enable only
    cyc(5'h00, 2'd1, 1, 0, 8'h02, "R8");
    cyc(5'h00, 2'd1, 0, 1, 8'h00, "R8 ctrl");
    // R2/R6 error event with error enable only
    cyc(5'h04, 2'd0, 0, 0, 8'h00, "R2");
    cyc(5'h00, 2'd0, 0, 1, 8'h00, "R2 flags");
    // R3 zero-write without prior read: consumed mark from the read above?
    // the read above set the mark, so first burn it with a ones-write
    cyc(5'h00, 2'd0, 1, 0, 8'hFF, "R3");
    cyc(5'h00, 2'd0, 1, 0, 8'h00, "R3");          // no mark: must not clear
    cyc(5'h00, 2'd0, 0, 1, 8'h00, "R3 unread zero-write");
    cyc(5'h00, 2'd0, 1, 0, 8'h00, "R3");          // marked: clears
    cyc(5'h00, 2'd0, 0, 1, 8'h00, "R3 cleared");

    // R4 set collides with clear
    cyc(5'h01, 2'd0, 0, 0, 8'h00, "R4");
    cyc(5'h00, 2'd0, 0, 1, 8'h00, "R4 pre");
    cyc(5'h01, 2'd0, 1, 0, 8'h00, "R4");
    cyc(5'h00, 2'd0, 0, 1, 8'h00, "R4 set wins");

    // R5 rx enable on, then off while break stays with error enable
    cyc(5'h10, 2'd1, 1, 0, 8'h03, "R5");
    cyc(5'h00, 2'd0, 0, 0, 8'h00, "R5");
    cyc(5'h00, 2'd1, 1, 0, 8'h02, "R5");
    cyc(5'h00, 2'd0, 0, 0, 8'h00, "R7");
    cyc(5'h00, 2'd1, 1, 0, 8'h00, "R7");
    cyc(5'h00, 2'd0, 0, 0, 8'h00, "R7");

    // R9 transmit gated by enable
    cyc(5'h00, 2'd2, 1, 0, 8'h5A, "R9");
    cyc(5'h00, 2'd1, 1, 0, 8'h04, "R9");
    cyc(5'h00, 2'd2, 1, 0, 8'hA5, "R9");
    cyc(5'h00, 2'd0, 0, 0, 8'h00, "R9");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] ev;
      logic [1:0] a;
      logic       we, re;
      for (int b = 0; b < 5; b++) ev[b] = ($urandom % 10) == 0;
      a  = 2'($urandom % 4);
      we = ($urandom % 4) == 0;
      re = ($urandom % 5) < 2;
      cyc(ev, a, we, re, 8'($urandom), a == 2'd1 ? "R8 rand" : "R2 R3 rand");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule